// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

A memory-mapped peripheral that lets several processors exchange 32-bit messages through a set of one-way hardware queues. A sender writes a queue's message register to push a word. A receiver reads the same register to pop the oldest word. Read-only registers give each queue's full flag and its fill level.

Each processor (a "user") owns a status register, an enable register and an interrupt line. Every queue raises two events: new-message when a word is accepted, and not-full when a word is removed. Event k of queue m sits at bit 2*m+k in every user's status and enable registers. A user's line is high while any status bit is both set and enabled.

A parameter selects one of two layouts for the per-user registers. The older layout has one directly written enable register. The newer layout has separate write-one-to-set and write-one-to-clear enable addresses. Bus access takes one cycle. Read data is combinational from the address, and a pop or push takes effect at the clock edge that ends the access.

Each queue is a three-state machine with the states Q_EMPTY, Q_PARTIAL and Q_FULL. It moves through these transitions:
- Q_EMPTY to Q_PARTIAL on the first push (straight to Q_FULL when the depth is one).
- Q_PARTIAL to Q_FULL on the push that fills it.
- Q_FULL to Q_PARTIAL on a pop.
- Q_PARTIAL to Q_EMPTY on the pop that drains it.
- Q_PARTIAL to Q_PARTIAL on any other push or pop.

A push in Q_FULL and a pop in Q_EMPTY are self-loops with no effect.

Top module: `ipc_mailbox`

## Requirements
- R1: Address 0x000 reads a constant identifier, with the major number in bits 7:4 and the minor number in bits 3:0 (defaults 2 and 0, so 0x20). Writes to it have no effect.
- R2: Writing address 0x040+4*m pushes a word into queue m. Reading that address returns the oldest word of queue m and removes it. The order is first in, first out, and queues are independent of each other.
- R3: Address 0x080+4*m reads 1 while queue m holds the queue depth (4) in words, and 0 otherwise. Address 0xC0+4*m reads the number of words held.
- R4: A push to a full queue is discarded, and the contents and level of that queue stay as they were.
- R5: A pop from an empty queue returns 0 and leaves the queue empty.
- R6: An accepted push into queue m sets bit 2*m in the status register of every user.
- R7: A pop that removes a word from queue m sets bit 2*m+1 in the status register of every user.
- R8: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged. If an event fires in the same cycle as the clear, the bit stays set.
- R9: The line irq[u] is high exactly when the status register and the enable register of user u have a common set bit.
- R10: In the older layout (NEW_LAYOUT=0), user u's status is at 0x100+8*u and its enable register is at 0x104+8*u. Written values replace the whole enable register, so writing 0 disables every event.
- R11: In the newer layout (NEW_LAYOUT=1), user u's status is at 0x104+16*u. Writing ones at 0x108+16*u sets enable bits, and writing ones at 0x10C+16*u clears them. Both addresses read back the enable register.
- R12: After reset all queues are empty, all status and enable bits are 0 and all interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address |
| irq | output | NUM_USERS | One interrupt line per user |

## Verification
The following are checked by assertions on every cycle:
- The queue level stays within the depth, and the Q_FULL state matches the level.
- A push to a full queue and a pop from an empty one leave the pointers and level untouched.
- Every event sets its status bit, and every write-one clear without a coincident event removes its bit.
- No line rises while its enable register is zero.

Only the bench scenarios can show the remaining behaviour:
- Word ordering through a queue, and the value returned by an empty pop.
- The exact address decoding of both register layouts.
- The fact that only writing 0 disables an event in the older layout.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

    // Occupancy states of one message queue
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;

    // Fixed register bases (byte addresses)
    localparam int ID_ADDR    = 'h000;
    localparam int MSG_BASE   = 'h040;
    localparam int FULL_BASE  = 'h080;
    localparam int LEVEL_BASE = 'h0C0;
    localparam int USER_BASE  = 'h100;
    localparam int WORD_BYTES = 4;

    // Per-user register placement for each layout
    function automatic int user_stride(input bit new_layout);
        return new_layout ? 16 : 8;
    endfunction

    function automatic int user_status_ofs(input bit new_layout);
        return new_layout ? 4 : 0;
    endfunction

    function automatic int user_enable_ofs(input bit new_layout);
        return new_layout ? 8 : 4;
    endfunction

    localparam int USER_DISABLE_OFS = 12;

endpackage

// File: rtl/ipc_mbx_queue.sv
module ipc_mbx_queue
    import ipc_mbx_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 4,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] push_data,
    output logic [DATA_W-1:0] head_data,
    output logic              is_full,
    output logic [CNT_W-1:0]  level,
    output logic              push_evt,
    output logic              pop_evt
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] LVL_MAX = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    q_state_e          st_q, st_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // Accepted operations: push wins if both were ever requested
    assign do_push = push_req && (st_q != Q_FULL);
    assign do_pop  = pop_req && !push_req && (st_q != Q_EMPTY);

    // Next-state logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            Q_EMPTY: begin
                if (do_push) begin
                    cnt_d = cnt_q + 1'b1;
                    st_d  = (DEPTH == 1) ? Q_FULL : Q_PARTIAL;
                end
            end
            Q_PARTIAL: begin
                if (do_push) begin
                    cnt_d = cnt_q + 1'b1;
                    st_d  = (cnt_q + 1'b1 == LVL_MAX) ? Q_FULL : Q_PARTIAL;
                end else if (do_pop) begin
                    cnt_d = cnt_q - 1'b1;
                    st_d  = (cnt_q == CNT_W'(1)) ? Q_EMPTY : Q_PARTIAL;
                end
            end
            Q_FULL: begin
                if (do_pop) begin
                    cnt_d = cnt_q - 1'b1;
                    st_d  = (DEPTH == 1) ? Q_EMPTY : Q_PARTIAL;
                end
            end
            default: begin
                st_d  = Q_EMPTY;
                cnt_d = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= Q_EMPTY;
            cnt_q <= '0;
            wr_q  <= '0;
            rd_q  <= '0;
        end else begin
            st_q <= st_d;
            cnt_q <= cnt_d;
            if (do_push) wr_q <= step(wr_q);
            if (do_pop)  rd_q <= step(rd_q);
        end
    end

    // Storage
    always_ff @(posedge clk) begin
        if (do_push) mem_q[wr_q] <= push_data;
    end

    // Outputs
    always_comb begin
        head_data = (st_q == Q_EMPTY) ? '0 : mem_q[rd_q];
        is_full   = (st_q == Q_FULL);
        level     = cnt_q;
        push_evt  = do_push;
        pop_evt   = do_pop;
    end

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LVL_MAX);

    a_r3_full_state_matches_level: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == Q_FULL) == (cnt_q == LVL_MAX));

    a_r4_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (is_full && push_req) |=> (level == $past(level) && $stable(wr_q) && $stable(rd_q)));

    a_r5_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == Q_EMPTY && pop_req && !push_req) |=> (cnt_q == '0 && $stable(rd_q)));

endmodule

// File: rtl/ipc_mbx_user.sv
module ipc_mbx_user #(
    parameter int EV_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] evt,
    input  logic [EV_W-1:0] stat_clr,
    input  logic [EV_W-1:0] en_set,
    input  logic [EV_W-1:0] en_clr,
    output logic [EV_W-1:0] status,
    output logic [EV_W-1:0] enable,
    output logic            irq
);

    logic [EV_W-1:0] status_q, enable_q;

    // Register update: a fresh event overrides a coincident clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= '0;
            enable_q <= '0;
        end else begin
            status_q <= (status_q & ~stat_clr) | evt;
            enable_q <= (enable_q | en_set) & ~en_clr;
        end
    end

    // Outputs
    always_comb begin
        status = status_q;
        enable = enable_q;
        irq    = |(status_q & enable_q);
    end

    a_r6_event_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_clr & ~evt)) |=> ((status & $past(stat_clr & ~evt)) == '0));

    a_r9_no_irq_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (enable == '0) |-> !irq);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter int         NUM_Q      = 8,
    parameter int         Q_DEPTH    = 4,
    parameter int         NUM_USERS  = 4,
    parameter bit         NEW_LAYOUT = 1'b1,
    parameter int         ADDR_W     = 10,
    parameter logic [3:0] REV_MAJOR  = 4'd2,
    parameter logic [3:0] REV_MINOR  = 4'd0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_USERS-1:0] irq
);

    localparam int EV_W   = 2 * NUM_Q;
    localparam int CNT_W  = $clog2(Q_DEPTH + 1);
    localparam int STRIDE = user_stride(NEW_LAYOUT);
    localparam int ST_OFS = user_status_ofs(NEW_LAYOUT);
    localparam int EN_OFS = user_enable_ofs(NEW_LAYOUT);
    localparam logic [ADDR_W-1:0] A_ID = ADDR_W'(ID_ADDR);

    logic wr_acc, rd_acc;
    assign wr_acc = bus_sel && bus_wr;
    assign rd_acc = bus_sel && !bus_wr;

    // Queue-side signals
    logic [NUM_Q-1:0] hit_msg, hit_full, hit_lvl;
    logic [NUM_Q-1:0] q_full, q_push_evt, q_pop_evt;
    logic [31:0]      q_head [NUM_Q];
    logic [CNT_W-1:0] q_lvl  [NUM_Q];
    logic [EV_W-1:0]  ev_vec;

    // User-side signals
    logic [NUM_USERS-1:0] hit_stat, hit_en_rd;
    logic [EV_W-1:0]      u_status [NUM_USERS];
    logic [EV_W-1:0]      u_enable [NUM_USERS];

    generate
        if (EV_W < 32) begin : g_spare
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^bus_wdata[31:EV_W];
        end

        for (genvar m = 0; m < NUM_Q; m++) begin : g_q
            localparam logic [ADDR_W-1:0] A_MSG  = ADDR_W'(MSG_BASE   + WORD_BYTES * m);
            localparam logic [ADDR_W-1:0] A_FULL = ADDR_W'(FULL_BASE  + WORD_BYTES * m);
            localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(LEVEL_BASE + WORD_BYTES * m);

            assign hit_msg[m]  = (bus_addr == A_MSG);
            assign hit_full[m] = (bus_addr == A_FULL);
            assign hit_lvl[m]  = (bus_addr == A_LVL);

            ipc_mbx_queue #(
                .DATA_W (32),
                .DEPTH  (Q_DEPTH)
            ) q_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .push_req  (wr_acc && hit_msg[m]),
                .pop_req   (rd_acc && hit_msg[m]),
                .push_data (bus_wdata),
                .head_data (q_head[m]),
                .is_full   (q_full[m]),
                .level     (q_lvl[m]),
                .push_evt  (q_push_evt[m]),
                .pop_evt   (q_pop_evt[m])
            );

            assign ev_vec[2*m]   = q_push_evt[m];
            assign ev_vec[2*m+1] = q_pop_evt[m];
        end

        for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
            localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(USER_BASE + STRIDE * u + ST_OFS);
            localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(USER_BASE + STRIDE * u + EN_OFS);
            logic [EV_W-1:0] st_clr, en_set, en_clr;
            logic            hit_en;

            assign hit_stat[u] = (bus_addr == A_ST);
            assign hit_en      = (bus_addr == A_EN);
            assign st_clr      = (wr_acc && hit_stat[u]) ? bus_wdata[EV_W-1:0] : '0;

            if (NEW_LAYOUT) begin : g_setclr
                localparam logic [ADDR_W-1:0] A_DIS =
                    ADDR_W'(USER_BASE + STRIDE * u + USER_DISABLE_OFS);
                logic hit_dis;
                assign hit_dis      = (bus_addr == A_DIS);
                assign hit_en_rd[u] = hit_en || hit_dis;
                assign en_set = (wr_acc && hit_en)  ? bus_wdata[EV_W-1:0] : '0;
                assign en_clr = (wr_acc && hit_dis) ? bus_wdata[EV_W-1:0] : '0;
            end else begin : g_direct
                assign hit_en_rd[u] = hit_en;
                assign en_set = (wr_acc && hit_en) ?  bus_wdata[EV_W-1:0] : '0;
                assign en_clr = (wr_acc && hit_en) ? ~bus_wdata[EV_W-1:0] : '0;
            end

            ipc_mbx_user #(
                .EV_W (EV_W)
            ) user_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .evt      (ev_vec),
                .stat_clr (st_clr),
                .en_set   (en_set),
                .en_clr   (en_clr),
                .status   (u_status[u]),
                .enable   (u_enable[u]),
                .irq      (irq[u])
            );
        end
    endgenerate

    // Read multiplexer: address hits are mutually exclusive
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_ID) bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
        for (int m = 0; m < NUM_Q; m++) begin
            if (hit_msg[m])  bus_rdata = q_head[m];
            if (hit_full[m]) bus_rdata = 32'(q_full[m]);
            if (hit_lvl[m])  bus_rdata = 32'(q_lvl[m]);
        end
        for (int u = 0; u < NUM_USERS; u++) begin
            if (hit_stat[u])  bus_rdata = 32'(u_status[u]);
            if (hit_en_rd[u]) bus_rdata = 32'(u_enable[u]);
        end
    end

    a_r12_irq_low_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (irq == '0));

endmodule

// File: tb/ipc_mailbox_tb_top.sv
module ipc_mailbox_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_n, rdata_l;
    logic [3:0]  irq_n, irq_l;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ipc_mailbox #(.NEW_LAYOUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_n), .irq(irq_n)
    );

    ipc_mailbox #(.NEW_LAYOUT(1'b0)) dut_leg_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_l), .irq(irq_l)
    );

    typedef struct packed {
        logic        wr;
        logic        chk;
        logic [15:0] tag;
        logic [9:0]  addr;
        logic [31:0] wd;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 25;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, "R1",  10'h000, 32'h0,         32'h20},        // R1 identifier
        '{1'b1, 1'b0, "R1",  10'h000, 32'hFFFF_FFFF, 32'h0},
        '{1'b0, 1'b1, "R1",  10'h000, 32'h0,         32'h20},        // R1 write ignored
        '{1'b0, 1'b1, "R12", 10'h0C0, 32'h0,         32'h0},         // R12 empty after reset
        '{1'b0, 1'b1, "R5",  10'h040, 32'h0,         32'h0},         // R5 empty pop reads 0
        '{1'b0, 1'b1, "R5",  10'h0C0, 32'h0,         32'h0},         // R5 still empty
        '{1'b1, 1'b0, "R2",  10'h040, 32'hA1A1_0001, 32'h0},
        '{1'b1, 1'b0, "R2",  10'h040, 32'hA1A1_0002, 32'h0},
        '{1'b1, 1'b0, "R2",  10'h040, 32'hA1A1_0003, 32'h0},
        '{1'b1, 1'b0, "R2",  10'h040, 32'hA1A1_0004, 32'h0},
        '{1'b0, 1'b1, "R3",  10'h080, 32'h0,         32'h1},         // R3 full flag
        '{1'b0, 1'b1, "R3",  10'h0C0, 32'h0,         32'h4},         // R3 level 4
        '{1'b1, 1'b0, "R4",  10'h040, 32'hA1A1_0005, 32'h0},
        '{1'b0, 1'b1, "R4",  10'h0C0, 32'h0,         32'h4},         // R4 level unchanged
        '{1'b0, 1'b1, "R2",  10'h040, 32'h0,         32'hA1A1_0001}, // R2 order
        '{1'b0, 1'b1, "R2",  10'h040, 32'h0,         32'hA1A1_0002},
        '{1'b0, 1'b1, "R3",  10'h080, 32'h0,         32'h0},         // R3 not full
        '{1'b0, 1'b1, "R3",  10'h0C0, 32'h0,         32'h2},
        '{1'b0, 1'b1, "R2",  10'h040, 32'h0,         32'hA1A1_0003},
        '{1'b0, 1'b1, "R4",  10'h040, 32'h0,         32'hA1A1_0004}, // R4 fifth word absent
        '{1'b0, 1'b1, "R5",  10'h040, 32'h0,         32'h0},
        '{1'b1, 1'b0, "R2",  10'h05C, 32'hB7B7_0007, 32'h0},
        '{1'b0, 1'b1, "R2",  10'h0DC, 32'h0,         32'h1},         // R2 queue 7 level
        '{1'b0, 1'b1, "R2",  10'h0C0, 32'h0,         32'h0},         // R2 queue 0 untouched
        '{1'b0, 1'b1, "R2",  10'h05C, 32'h0,         32'hB7B7_0007}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic acc(input logic wr, input logic [9:0] addr, input logic [31:0] wd,
                       output logic [31:0] rn, output logic [31:0] rl);
        @(negedge clk);
        bus_sel   = 1'b1;
        bus_wr    = wr;
        bus_addr  = addr;
        bus_wdata = wd;
        #2;
        rn = rdata_n;
        rl = rdata_l;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic wr_reg(input logic [9:0] addr, input logic [31:0] wd);
        logic [31:0] dn, dl;
        acc(1'b1, addr, wd, dn, dl);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rn, rl;
        do_reset();
        // R12: reset state of the lines
        check("R12", 32'(irq_n), 32'h0);
        check("R12", 32'(irq_l), 32'h0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i].wr, VEC[i].addr, VEC[i].wd, rn, rl);
            if (VEC[i].chk) check(string'(VEC[i].tag), rn, VEC[i].exp);
        end

        // Newer layout, user 1: status 0x114, set 0x118, clear 0x11C
        do_reset();
        acc(1'b0, 10'h114, 32'h0, rn, rl);
        check("R12", rn, 32'h0);
        wr_reg(10'h048, 32'hC2C2_0002);
        acc(1'b0, 10'h114, 32'h0, rn, rl);
        check("R6", rn, 32'h10);
        check("R9", 32'(irq_n), 32'h0);
        wr_reg(10'h118, 32'h10);
        check("R9", 32'(irq_n), 32'h2);
        acc(1'b0, 10'h118, 32'h0, rn, rl);
        check("R11", rn, 32'h10);
        acc(1'b0, 10'h11C, 32'h0, rn, rl);
        check("R11", rn, 32'h10);
        acc(1'b0, 10'h048, 32'h0, rn, rl);
        check("R2", rn, 32'hC2C2_0002);
        acc(1'b0, 10'h114, 32'h0, rn, rl);
        check("R7", rn, 32'h30);
        acc(1'b0, 10'h104, 32'h0, rn, rl);
        check("R6", rn, 32'h30);
        wr_reg(10'h114, 32'h10);
        acc(1'b0, 10'h114, 32'h0, rn, rl);
        check("R8", rn, 32'h20);
        check("R9", 32'(irq_n), 32'h0);
        wr_reg(10'h114, 32'h0);
        acc(1'b0, 10'h114, 32'h0, rn, rl);
        check("R8", rn, 32'h20);
        wr_reg(10'h11C, 32'h10);
        acc(1'b0, 10'h118, 32'h0, rn, rl);
        check("R11", rn, 32'h0);
        wr_reg(10'h118, 32'h20);
        check("R9", 32'(irq_n), 32'h2);
        wr_reg(10'h11C, 32'h20);
        check("R11", 32'(irq_n), 32'h0);

        // Older layout, user 2: status 0x110, enable 0x114
        do_reset();
        wr_reg(10'h044, 32'hD1D1_0001);
        acc(1'b0, 10'h110, 32'h0, rn, rl);
        check("R10", rl, 32'h4);
        wr_reg(10'h114, 32'h4);
        check("R10", 32'(irq_l), 32'h4);
        acc(1'b0, 10'h114, 32'h0, rn, rl);
        check("R10", rl, 32'h4);
        wr_reg(10'h114, 32'h0);
        check("R10", 32'(irq_l), 32'h0);
        acc(1'b0, 10'h114, 32'h0, rn, rl);
        check("R10", rl, 32'h0);
        wr_reg(10'h110, 32'h4);
        acc(1'b0, 10'h110, 32'h0, rn, rl);
        check("R8", rl, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule